// File: doc/BRIEF.md
# Sleep control register with timed brown-out unlock

The block is an 8-bit power-management control register on a simple single-cycle CPU write/read bus. It stores the sleep-enable bit, the two sleep-mode select bits, and some unrelated storage bits: a pull-up disable and two interrupt sense bits. When the CPU executes a sleep instruction, the block receives a one-cycle strobe. If sleep is enabled, it answers with a one-cycle sleep request and the selected mode.

Bit 7 lets software switch the brown-out detector off for one sleep. Software cannot set this bit with a plain write. It must first make an arming write, which sets bits 7 and 2 together. It must then make a committing write, which sets bit 7 with bit 2 clear, within four clock cycles of the arming write.

Once committed, the bit becomes effective three cycles later and clears itself three cycles after that. A sleep strobe that arrives while the bit is effective sets a latched brown-out-off flag. A wake pulse clears this flag.

Top module: `slp_ctrl_reg`

## Requirements
- R1: After reset, the read data is 0x00, and sleep_req_o, sleep_mode_o and bod_off_o are 0.
- R2: Bits 6, 5, 4, 3, 1 and 0 are plain storage. Every write stores them, and a read returns them unchanged in the same positions.
- R3: When sleep_i is sampled high while bit 5 is 1, sleep_req_o is 1 for the following cycle. From then on, sleep_mode_o holds bits 4:3 as they were at the strobe (00 idle, 01 ADC quiet, 10 power-down, 11 standby) until the next accepted strobe.
- R4: While bit 5 is 0, a sleep strobe is ignored: sleep_req_o stays 0 and sleep_mode_o keeps its value.
- R5: A write with bits 7 and 2 both 1 is the arming write.
  - After the arming write, bit 2 reads 1 for four cycles, and hardware then clears it.
  - The arming write leaves bit 7 unchanged.
  - Any later write clears bit 2 at once.
- R6: A write with bit 7 at 1 and bit 2 at 0 is the committing write.
  - It is accepted on any of the four clock edges after the arming write.
  - Once accepted, bit 7 reads 1 for six cycles and then returns to 0.
- R7: A write of bit 7 does not set it in two cases: when no arming write precedes it, and when it comes on the fifth edge after the arming write or later.
- R8: bod_off_o is set one cycle after an accepted sleep strobe only while bit 7 is effective. Bit 7 is effective on the fourth, fifth and sixth edges after the commit. A strobe during the first three cycles does not set bod_off_o.
- R9: Once set, bod_off_o stays 1 until wake_i is sampled high, unless a new qualifying strobe arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Live register contents |
| sleep_i | input | 1 | Sleep instruction strobe |
| wake_i | input | 1 | Wake pulse, clears bod_off_o |
| sleep_req_o | output | 1 | One-cycle sleep request |
| sleep_mode_o | output | 2 | Mode captured at the last accepted strobe |
| bod_off_o | output | 1 | Brown-out detector off for this sleep |

## Verification
Every result is registered, so it appears one edge after the inputs that cause it are sampled. This covers read data after a write, the sleep request, the mode and the brown-out flag. The bench drives inputs on the falling edge and compares all outputs on the next falling edge, against a cycle model kept in the bench.

The unlock window and the self-clearing bit 7 are counted in edges from the arming write and from the committing write. The directed cases place commits on the fourth and fifth edges, and sleep strobes on the third and fourth edges after a commit. These land on both sides of each boundary.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_BODS  = 7;
  localparam int BIT_SE    = 5;
  localparam int BIT_SM_LO = 3;
  localparam int BIT_UNLK  = 2;
  localparam logic [REG_W-1:0] PLAIN_MASK = 8'h7B;

  typedef enum logic [1:0] {
    MODE_IDLE      = 2'b00,
    MODE_ADC_QUIET = 2'b01,
    MODE_PWR_DOWN  = 2'b10,
    MODE_STANDBY   = 2'b11
  } slp_mode_e;
endpackage

// File: rtl/slp_unlock.sv
module slp_unlock #(
  parameter int WIN  = 4,
  parameter int DLY  = 3,
  parameter int HOLD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic arm_i,
  input  logic commit_i,
  output logic unlock_o,
  output logic bods_o,
  output logic eff_o
);
  localparam int WW = $clog2(WIN + 1);
  localparam int BW = $clog2(DLY + HOLD + 1);
  localparam logic [WW-1:0] WIN_L  = WW'(WIN);
  localparam logic [BW-1:0] LOAD_L = BW'(DLY + HOLD);
  localparam logic [BW-1:0] HOLD_L = BW'(HOLD);

  logic [WW-1:0] win_q;
  logic [BW-1:0] bods_q;

  // any write rewrites the arm state; otherwise count the window down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              win_q <= '0;
    else if (wr_i)            win_q <= arm_i ? WIN_L : '0;
    else if (win_q != '0)     win_q <= win_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         bods_q <= '0;
    else if (commit_i && win_q != '0)    bods_q <= LOAD_L;
    else if (bods_q != '0)               bods_q <= bods_q - 1'b1;
  end

  assign unlock_o = (win_q != '0);
  assign bods_o   = (bods_q != '0);
  assign eff_o    = (bods_q != '0) && (bods_q <= HOLD_L);
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       wake_i,
  input  logic       se_i,
  input  logic [1:0] sm_i,
  input  logic       eff_i,
  output logic       req_o,
  output logic [1:0] mode_o,
  output logic       bod_off_o
);
  slp_mode_e mode_q;
  logic      req_q, bod_q;
  logic      take;

  assign take = sleep_i && se_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      mode_q <= MODE_IDLE;
      bod_q  <= 1'b0;
    end else begin
      req_q <= take;
      if (take) mode_q <= slp_mode_e'(sm_i);
      if (take && eff_i) bod_q <= 1'b1;
      else if (wake_i)   bod_q <= 1'b0;
    end
  end

  assign req_o     = req_q;
  assign mode_o    = mode_q;
  assign bod_off_o = bod_q;
endmodule

// File: rtl/slp_ctrl_reg.sv
module slp_ctrl_reg
  import slp_pkg::*;
#(
  parameter int WIN  = 4,
  parameter int DLY  = 3,
  parameter int HOLD = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             sleep_i,
  input  logic             wake_i,
  output logic             sleep_req_o,
  output logic [1:0]       sleep_mode_o,
  output logic             bod_off_o
);
  logic [REG_W-1:0] plain_q;
  logic unlock, bods, eff, arm, commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      plain_q <= '0;
    else if (wr_en_i) plain_q <= wr_data_i & PLAIN_MASK;
  end

  assign arm    = wr_data_i[BIT_BODS] &&  wr_data_i[BIT_UNLK];
  assign commit = wr_en_i && wr_data_i[BIT_BODS] && !wr_data_i[BIT_UNLK];

  slp_unlock #(.WIN(WIN), .DLY(DLY), .HOLD(HOLD)) u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i),
    .arm_i    (arm),
    .commit_i (commit),
    .unlock_o (unlock),
    .bods_o   (bods),
    .eff_o    (eff)
  );

  slp_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .wake_i    (wake_i),
    .se_i      (plain_q[BIT_SE]),
    .sm_i      (plain_q[BIT_SM_LO+1:BIT_SM_LO]),
    .eff_i     (eff),
    .req_o     (sleep_req_o),
    .mode_o    (sleep_mode_o),
    .bod_off_o (bod_off_o)
  );

  always_comb begin
    rd_data_o           = plain_q;
    rd_data_o[BIT_BODS] = bods;
    rd_data_o[BIT_UNLK] = unlock;
  end
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] rd_data_o,
  input logic       sleep_i,
  input logic       wake_i,
  input logic       sleep_req_o,
  input logic [1:0] sleep_mode_o,
  input logic       bod_off_o
);
  p_req_needs_se_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |-> ($past(sleep_i) && $past(rd_data_o[5])));

  p_no_req_se_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sleep_i) && !$past(rd_data_o[5])) |-> !sleep_req_o);

  p_mode_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_req_o |-> $stable(sleep_mode_o));

  p_bods_needs_unlock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[7]) |-> ($past(rd_data_o[2]) && $past(wr_en_i)));

  p_bod_rise_on_sleep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bod_off_o) |-> ($past(sleep_i) && sleep_req_o && $past(rd_data_o[7])));

  p_bod_fall_on_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bod_off_o) |-> $past(wake_i));
endmodule

bind slp_ctrl_reg slp_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .rd_data_o    (rd_data_o),
  .sleep_i      (sleep_i),
  .wake_i       (wake_i),
  .sleep_req_o  (sleep_req_o),
  .sleep_mode_o (sleep_mode_o),
  .bod_off_o    (bod_off_o)
);

// File: tb/slp_ctrl_reg_tb.sv
module slp_ctrl_reg_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       sleep_i = 1'b0;
  logic       wake_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       sleep_req_o;
  logic [1:0] sleep_mode_o;
  logic       bod_off_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [7:0] m_plain = 8'h00;
  int         m_win = 0;
  int         m_bods = 0;
  logic       m_req = 1'b0;
  logic [1:0] m_mode = 2'b00;
  logic       m_bod = 1'b0;

  always #10 clk_i = ~clk_i;

  slp_ctrl_reg u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .sleep_i(sleep_i), .wake_i(wake_i),
    .sleep_req_o(sleep_req_o), .sleep_mode_o(sleep_mode_o), .bod_off_o(bod_off_o)
  );

  function automatic logic [7:0] exp_rd();
    logic [7:0] r;
    r = m_plain;
    r[7] = (m_bods != 0);
    r[2] = (m_win != 0);
    return r;
  endfunction

  function automatic logic exp_eff();
    return (m_bods >= 1) && (m_bods <= 3);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    check({tag, " rd_data"}, int'(rd_data_o), int'(exp_rd()));
    check({tag, " sleep_req"}, int'(sleep_req_o), int'(m_req));
    check({tag, " sleep_mode"}, int'(sleep_mode_o), int'(m_mode));
    check({tag, " bod_off"}, int'(bod_off_o), int'(m_bod));
  endtask

  // one clock: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic cyc(input logic w, input logic [7:0] d, input logic s, input logic k,
                     input string tag);
    logic take, eff;
    wr_en_i = w; wr_data_i = d; sleep_i = s; wake_i = k;
    take = s && m_plain[5];
    eff = exp_eff();
    m_req = take;
    if (take) m_mode = m_plain[4:3];
    if (take && eff) m_bod = 1'b1;
    else if (k) m_bod = 1'b0;
    if (w && d[7] && !d[2] && m_win > 0) m_bods = 6;
    else if (m_bods > 0) m_bods--;
    if (w) m_win = (d[7] && d[2]) ? 4 : 0;
    else if (m_win > 0) m_win--;
    if (w) m_plain = d & 8'h7B;
    @(negedge clk_i);
    wr_en_i = 1'b0; sleep_i = 1'b0; wake_i = 1'b0;
    cmp_all(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] d;
    int r;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk_i);
    cmp_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp_all("R1 after reset");

    cyc(1'b1, 8'h7B, 1'b0, 1'b0, "R2 plain all ones");
    check("R2 readback", int'(rd_data_o), 32'h7B);
    cyc(1'b1, 8'h41, 1'b0, 1'b0, "R2 plain pattern");
    check("R2 readback pattern", int'(rd_data_o), 32'h41);

    for (int m = 0; m < 4; m++) begin
      cyc(1'b1, 8'h20 | 8'(m << 3), 1'b0, 1'b0, "R3 set mode");
      cyc(1'b0, 8'h00, 1'b1, 1'b0, "R3 strobe");
      check("R3 req pulse", int'(sleep_req_o), 1);
      check("R3 mode", int'(sleep_mode_o), m);
      idle(1, "R3 req drops");
      check("R3 req low", int'(sleep_req_o), 0);
    end

    cyc(1'b1, 8'h08, 1'b0, 1'b0, "R4 se off");
    cyc(1'b0, 8'h00, 1'b1, 1'b0, "R4 strobe ignored");
    check("R4 no req", int'(sleep_req_o), 0);
    check("R4 mode kept", int'(sleep_mode_o), 3);

    cyc(1'b1, 8'h84, 1'b0, 1'b0, "R5 arm");
    check("R5 unlock set, bods clear", int'(rd_data_o), 32'h04);
    idle(3, "R5 window");
    check("R5 unlock still set", int'(rd_data_o[2]), 1);
    idle(1, "R5 expire");
    check("R5 unlock cleared", int'(rd_data_o[2]), 0);
    cyc(1'b1, 8'h84, 1'b0, 1'b0, "R5 arm again");
    cyc(1'b1, 8'h01, 1'b0, 1'b0, "R5 cancel by write");
    check("R5 cancelled", int'(rd_data_o), 32'h01);

    cyc(1'b1, 8'h84, 1'b0, 1'b0, "R6 arm");
    idle(3, "R6 wait");
    cyc(1'b1, 8'h80, 1'b0, 1'b0, "R6 commit on 4th edge");
    check("R6 bods set", int'(rd_data_o[7]), 1);
    idle(5, "R6 hold");
    check("R6 bods still set", int'(rd_data_o[7]), 1);
    idle(1, "R6 self clear");
    check("R6 bods cleared", int'(rd_data_o[7]), 0);

    cyc(1'b1, 8'h84, 1'b0, 1'b0, "R7 arm");
    idle(4, "R7 wait");
    cyc(1'b1, 8'h80, 1'b0, 1'b0, "R7 late commit");
    check("R7 late rejected", int'(rd_data_o[7]), 0);
    cyc(1'b1, 8'h80, 1'b0, 1'b0, "R7 bare write");
    check("R7 bare rejected", int'(rd_data_o[7]), 0);

    // strobe on 3rd edge after commit: not effective
    cyc(1'b1, 8'hA4, 1'b0, 1'b0, "R8 arm with se");
    cyc(1'b1, 8'hA0, 1'b0, 1'b0, "R8 commit");
    idle(2, "R8 delay");
    cyc(1'b0, 8'h00, 1'b1, 1'b0, "R8 early strobe");
    check("R8 early no bod", int'(bod_off_o), 0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, "R8 effective strobe");
    check("R8 bod set", int'(bod_off_o), 1);
    idle(6, "R9 hold");
    check("R9 bod held", int'(bod_off_o), 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, "R9 wake");
    check("R9 bod cleared", int'(bod_off_o), 0);

    for (int i = 0; i < 4000; i++) begin
      r = $urandom % 8;
      d = 8'($urandom);
      if (r < 2)      d = (d & 8'h7B) | 8'h84;
      else if (r < 4) d = (d & 8'h7B & ~8'h04) | 8'h80;
      cyc(($urandom % 10) < 4, d, ($urandom % 5) == 0, ($urandom % 10) == 0,
          "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule